// File: doc/BRIEF.md
# DMA Channel Loop Sequencer

This block is the control core of one DMA channel thread. After a start pulse it fetches a byte-coded channel program from a small instruction memory, one byte per cycle, starting at the address given with the pulse. It decodes instructions that are one to six bytes long, keeps two hardware loop counters, takes backward jumps at loop ends, and stops on an end or kill instruction. Each data-movement instruction produces one single-cycle command on a memory-operation port. The command is tagged as load, store or store-zero, and as single or burst. The data movers behind that port do the actual bus transfers.

The channel reports a 4-bit state code and a fault flag. Instructions that need a peripheral handshake, an event or an address update do not act inside this block. They are fetched for their full length and retired as no-operations, so a complete program still runs through the sequencer.

Top module: `lpseq_core`

## Requirements
- R1: While reset is high and in the cycle after it is released, the channel state is stopped (0), the fault flag is low and no operation command is issued.
- R2: A start pulse taken while stopped loads the fetch address with the start address in the next cycle, and the state becomes executing (1). With no start pulse, a stopped channel stays stopped.
- R3: Instruction lengths are decoded from the opcode byte. The following are 1 byte long: 0x00 end, 0x01 kill, 0x04/05/07 load, 0x08/09/0B store, 0x0C store-zero, 0x12, 0x13 and 0x18. The following are 2 bytes long: 0x20/22 loop start; loop end 0x28/2C and 0x38/39/3B/3C/3D/3F; 0x25/27, 0x29/2B, 0x30/31/32, 0x34, 0x35 and 0x36. Opcodes 0x54/56 are 3 bytes long and 0xBC is 6 bytes long. All operand bytes are consumed; none is ever decoded as an opcode. The instructions 0x12, 0x13, 0x18, 0x25/27, 0x29/2B, 0x30-0x32, 0x34-0x36 and 0x54/56 retire with no effect.
- R4: Loop start (0x20 / 0x22) loads its second byte into loop counter 0 or 1, as selected by opcode bit 1. A stored value N yields N+1 passes of the loop body.
- R5: A counted loop end (opcode bit 4 set) uses the counter selected by opcode bit 2. If that counter is nonzero, it is decremented and execution continues at the loop-end opcode address minus the second byte. If the counter is zero, execution falls through. The condition bits 1:0 (00 always, 01 single, 11 burst) are treated as met.
- R6: A forever loop end (0x28 / 0x2C) always jumps back and leaves the counters untouched.
- R7: Each load, store or store-zero gives exactly one cycle of `op_valid_o`, while the state is executing. The kind code is 1 for load, 2 for store and 3 for store-zero. `op_burst_o` is 1 only when opcode bits 1:0 are 11.
- R8: End (0x00) shows completing (9) for one cycle and then stopped (0). Kill (0x01) shows killing (8) for one cycle and then stopped.
- R9: An undefined opcode byte (for example 0x02, 0xA0 or 0xFF) enters faulting (0xF) and raises `fault_o`. Both hold until reset, and no further command is issued.
- R10: Opcode 0xBC retires normally when its selector byte (byte 1) is 0, 1 or 2. With any other selector value it faults as in R9.
- R11: A start pulse while the channel is not stopped is ignored.
- R12: Fetch addresses and jump targets wrap modulo 2^ADDR_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start pulse, taken only while stopped |
| start_addr_i | input | ADDR_W | Address of the first program byte |
| fetch_addr_o | output | ADDR_W | Address of the program byte being fetched |
| fetch_data_i | input | 8 | Program byte at `fetch_addr_o`, same cycle |
| op_valid_o | output | 1 | One-cycle memory-operation command |
| op_kind_o | output | 2 | 1 load, 2 store, 3 store-zero |
| op_burst_o | output | 1 | Command is a burst (1) or single (0) |
| chan_state_o | output | 4 | Channel state code |
| fault_o | output | 1 | Channel is faulting |

## Verification
The bench instantiates the block with ADDR_W = 8. This makes the address space small enough that a nested-loop program can straddle the top of memory, so both sequential fetch and backward loop-end jumps cross the wrap point. The loop counters keep their full 8-bit width. One vector uses an inner count of 255, which reaches the largest single-counter iteration count, with more than a thousand store-zero commands in one run. The other vectors vary the loop counts, the body opcode and its single/burst tag, the loop-end condition bits and the end-versus-kill exit. Each vector checks that the number of commands equals the product of the two pass counts.

// File: rtl/lpseq_pkg.sv
`timescale 1ns/1ps
package lpseq_pkg;

    localparam int CNT_W     = 8;   // loop counter width, one operand byte
    localparam int LOOP_CTRS = 2;   // number of hardware loop counters
    localparam int LEN_W     = 3;   // instruction length field, 1..6 bytes

    typedef enum logic [3:0] {
        CH_STOPPED          = 4'h0,
        CH_EXECUTING        = 4'h1,
        CH_CACHE_MISS       = 4'h2,
        CH_UPDATE_PC        = 4'h3,
        CH_WAIT_EVENT       = 4'h4,
        CH_BARRIER          = 4'h5,
        CH_QUEUE_BUSY       = 4'h6,
        CH_WAIT_PERIPH      = 4'h7,
        CH_KILLING          = 4'h8,
        CH_COMPLETING       = 4'h9,
        CH_FAULT_COMPLETING = 4'hE,
        CH_FAULTING         = 4'hF
    } chan_state_e;

    typedef enum logic [1:0] {
        MOP_NONE  = 2'd0,
        MOP_LOAD  = 2'd1,
        MOP_STORE = 2'd2,
        MOP_ZERO  = 2'd3
    } memop_e;

    typedef enum logic [2:0] {
        IC_BAD, IC_END, IC_KILL, IC_MEMOP, IC_SKIP, IC_LOOP, IC_LOOPEND, IC_MOVE
    } iclass_e;

    typedef enum logic [2:0] {
        PH_IDLE, PH_OPC, PH_ARG, PH_EXEC, PH_DONE, PH_FAULT
    } phase_e;

    typedef struct packed {
        iclass_e           cls;
        logic [LEN_W-1:0]  len;
        memop_e            mop;
        logic              burst;
        logic              sel;
        logic              counted;
    } idec_t;

    function automatic idec_t decode_op(input logic [7:0] b);
        idec_t r;
        r.cls     = IC_BAD;
        r.len     = LEN_W'(1);
        r.mop     = MOP_NONE;
        r.burst   = (b[1:0] == 2'b11);
        r.sel     = b[1];
        r.counted = 1'b0;
        case (b)
            8'h00: r.cls = IC_END;
            8'h01: r.cls = IC_KILL;
            8'h04, 8'h05, 8'h07: begin r.cls = IC_MEMOP; r.mop = MOP_LOAD;  end
            8'h08, 8'h09, 8'h0B: begin r.cls = IC_MEMOP; r.mop = MOP_STORE; end
            8'h0C:               begin r.cls = IC_MEMOP; r.mop = MOP_ZERO;  end
            8'h12, 8'h13, 8'h18: r.cls = IC_SKIP;
            8'h20, 8'h22: begin r.cls = IC_LOOP; r.len = LEN_W'(2); end
            8'h28, 8'h2C: begin
                r.cls = IC_LOOPEND; r.len = LEN_W'(2); r.sel = b[2];
            end
            8'h38, 8'h39, 8'h3B, 8'h3C, 8'h3D, 8'h3F: begin
                r.cls = IC_LOOPEND; r.len = LEN_W'(2); r.sel = b[2]; r.counted = 1'b1;
            end
            8'h25, 8'h27, 8'h29, 8'h2B, 8'h30, 8'h31, 8'h32,
            8'h34, 8'h35, 8'h36: begin r.cls = IC_SKIP; r.len = LEN_W'(2); end
            8'h54, 8'h56: begin r.cls = IC_SKIP; r.len = LEN_W'(3); end
            8'hBC:        begin r.cls = IC_MOVE; r.len = LEN_W'(6); end
            default: r.cls = IC_BAD;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/lpseq_decode.sv
`timescale 1ns/1ps
module lpseq_decode
    import lpseq_pkg::*;
(
    input  logic [7:0] opc_i,
    output idec_t      dec_o
);
    assign dec_o = decode_op(opc_i);
endmodule

// File: rtl/lpseq_pc.sv
`timescale 1ns/1ps
module lpseq_pc #(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_en,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              mark_en,
    input  logic              step_en,
    input  logic              jump_en,
    input  logic [7:0]        jump_dist,
    output logic [ADDR_W-1:0] pc_o
);
    logic [ADDR_W-1:0] pc_q;
    logic [ADDR_W-1:0] ins_q;   // address of the opcode byte in flight

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q  <= '0;
            ins_q <= '0;
        end else begin
            if (mark_en)
                ins_q <= pc_q;
            if (load_en)
                pc_q <= load_val;
            else if (jump_en)
                pc_q <= ins_q - ADDR_W'(jump_dist);
            else if (step_en)
                pc_q <= pc_q + 1'b1;
        end
    end

    assign pc_o = pc_q;
endmodule

// File: rtl/lpseq_loopctr.sv
`timescale 1ns/1ps
module lpseq_loopctr #(
    parameter int NCTR = 2,
    parameter int CW   = 8,
    localparam int SELW = (NCTR > 1) ? $clog2(NCTR) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [SELW-1:0] sel,
    input  logic            ld_en,
    input  logic [CW-1:0]   ld_val,
    input  logic            dec_en,
    output logic            zero_o
);
    logic [CW-1:0] cnt_q [NCTR];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int g = 0; g < NCTR; g++) cnt_q[g] <= '0;
        end else begin
            for (int g = 0; g < NCTR; g++) begin
                if (sel == SELW'(g)) begin
                    if (ld_en)
                        cnt_q[g] <= ld_val;
                    else if (dec_en && (cnt_q[g] != '0))
                        cnt_q[g] <= cnt_q[g] - 1'b1;
                end
            end
        end
    end

    assign zero_o = (cnt_q[sel] == '0);
endmodule

// File: rtl/lpseq_opout.sv
`timescale 1ns/1ps
module lpseq_opout
    import lpseq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   fire,
    input  memop_e mop,
    input  logic   burst,
    output logic   valid_o,
    output memop_e kind_o,
    output logic   burst_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            valid_o <= 1'b0;
            kind_o  <= MOP_NONE;
            burst_o <= 1'b0;
        end else begin
            valid_o <= fire;
            kind_o  <= fire ? mop : MOP_NONE;
            burst_o <= fire & burst;
        end
    end
endmodule

// File: rtl/lpseq_core.sv
`timescale 1ns/1ps
module lpseq_core
    import lpseq_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] start_addr_i,
    output logic [ADDR_W-1:0] fetch_addr_o,
    input  logic [7:0]        fetch_data_i,
    output logic              op_valid_o,
    output logic [1:0]        op_kind_o,
    output logic              op_burst_o,
    output logic [3:0]        chan_state_o,
    output logic              fault_o
);
    localparam int SELW = (LOOP_CTRS > 1) ? $clog2(LOOP_CTRS) : 1;

    phase_e           phase_q, phase_d;
    idec_t            dec_q, dec_now;
    logic [7:0]       arg0_q;
    logic [LEN_W-1:0] left_q;
    logic             kill_q;

    logic pc_load, pc_mark, pc_step, pc_jump;
    logic ctr_ld, ctr_dec, ctr_zero;
    logic op_fire;
    memop_e op_kind;

    lpseq_decode u_dec (
        .opc_i (fetch_data_i),
        .dec_o (dec_now)
    );

    lpseq_pc #(.ADDR_W(ADDR_W)) u_pc (
        .clk       (clk),
        .rst       (rst),
        .load_en   (pc_load),
        .load_val  (start_addr_i),
        .mark_en   (pc_mark),
        .step_en   (pc_step),
        .jump_en   (pc_jump),
        .jump_dist (arg0_q),
        .pc_o      (fetch_addr_o)
    );

    lpseq_loopctr #(.NCTR(LOOP_CTRS), .CW(CNT_W)) u_ctr (
        .clk    (clk),
        .rst    (rst),
        .sel    (SELW'(dec_q.sel)),
        .ld_en  (ctr_ld),
        .ld_val (arg0_q),
        .dec_en (ctr_dec),
        .zero_o (ctr_zero)
    );

    lpseq_opout u_op (
        .clk     (clk),
        .rst     (rst),
        .fire    (op_fire),
        .mop     (dec_q.mop),
        .burst   (dec_q.burst),
        .valid_o (op_valid_o),
        .kind_o  (op_kind),
        .burst_o (op_burst_o)
    );

    assign op_kind_o = op_kind;

    always_comb begin
        phase_d = phase_q;
        pc_load = 1'b0;
        pc_mark = 1'b0;
        pc_step = 1'b0;
        pc_jump = 1'b0;
        ctr_ld  = 1'b0;
        ctr_dec = 1'b0;
        op_fire = 1'b0;
        case (phase_q)
            PH_IDLE: begin
                if (start_i) begin
                    pc_load = 1'b1;
                    phase_d = PH_OPC;
                end
            end
            PH_OPC: begin
                pc_mark = 1'b1;
                if (dec_now.cls == IC_BAD) begin
                    phase_d = PH_FAULT;
                end else begin
                    pc_step = 1'b1;
                    phase_d = (dec_now.len == LEN_W'(1)) ? PH_EXEC : PH_ARG;
                end
            end
            PH_ARG: begin
                pc_step = 1'b1;
                if (left_q == LEN_W'(1))
                    phase_d = PH_EXEC;
            end
            PH_EXEC: begin
                phase_d = PH_OPC;
                case (dec_q.cls)
                    IC_END, IC_KILL: phase_d = PH_DONE;
                    IC_MEMOP:        op_fire = 1'b1;
                    IC_SKIP:         ;
                    IC_LOOP:         ctr_ld  = 1'b1;
                    IC_LOOPEND: begin
                        if (dec_q.counted) begin
                            ctr_dec = 1'b1;
                            pc_jump = !ctr_zero;
                        end else begin
                            pc_jump = 1'b1;
                        end
                    end
                    IC_MOVE: begin
                        if (arg0_q > 8'd2)
                            phase_d = PH_FAULT;
                    end
                    default: phase_d = PH_FAULT;
                endcase
            end
            PH_DONE:  phase_d = PH_IDLE;
            PH_FAULT: phase_d = PH_FAULT;
            default:  phase_d = PH_FAULT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            dec_q   <= '0;
            arg0_q  <= '0;
            left_q  <= '0;
            kill_q  <= 1'b0;
        end else begin
            phase_q <= phase_d;
            if (phase_q == PH_OPC) begin
                dec_q  <= dec_now;
                left_q <= dec_now.len - LEN_W'(1);
            end
            if (phase_q == PH_ARG) begin
                left_q <= left_q - LEN_W'(1);
                if (left_q == dec_q.len - LEN_W'(1))
                    arg0_q <= fetch_data_i;
            end
            if (phase_q == PH_EXEC)
                kill_q <= (dec_q.cls == IC_KILL);
        end
    end

    chan_state_e state_w;
    always_comb begin
        case (phase_q)
            PH_IDLE:                  state_w = CH_STOPPED;
            PH_OPC, PH_ARG, PH_EXEC:  state_w = CH_EXECUTING;
            PH_DONE:                  state_w = kill_q ? CH_KILLING : CH_COMPLETING;
            default:                  state_w = CH_FAULTING;
        endcase
    end

    assign chan_state_o = state_w;
    assign fault_o      = (phase_q == PH_FAULT);
endmodule

// File: rtl/lpseq_core_chk.sv
`timescale 1ns/1ps
module lpseq_core_chk (
    input logic       clk,
    input logic       rst,
    input logic       start_i,
    input logic       op_valid_o,
    input logic [1:0] op_kind_o,
    input logic [3:0] chan_state_o,
    input logic       fault_o
);
    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (chan_state_o == 4'h0 && !start_i) |=> (chan_state_o == 4'h0));

    assert_kind_tag_R7: assert property (@(posedge clk) disable iff (rst)
        op_valid_o |-> (op_kind_o != 2'd0));

    assert_op_in_exec_R7: assert property (@(posedge clk) disable iff (rst)
        op_valid_o |-> (chan_state_o == 4'h1));

    assert_end_exit_R8: assert property (@(posedge clk) disable iff (rst)
        (chan_state_o == 4'h9) |=> (chan_state_o == 4'h0));

    assert_kill_exit_R8: assert property (@(posedge clk) disable iff (rst)
        (chan_state_o == 4'h8) |=> (chan_state_o == 4'h0));

    assert_fault_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        fault_o |=> (fault_o && chan_state_o == 4'hF));

    assert_fault_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        fault_o |-> (!op_valid_o && chan_state_o == 4'hF));
endmodule

bind lpseq_core lpseq_core_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .start_i      (start_i),
    .op_valid_o   (op_valid_o),
    .op_kind_o    (op_kind_o),
    .chan_state_o (chan_state_o),
    .fault_o      (fault_o)
);

// File: tb/lpseq_core_test.sv
`timescale 1ns/1ps
module lpseq_core_test;

    localparam int AW = 8;

    typedef struct packed {
        logic [7:0] base;
        logic [7:0] c1;
        logic [7:0] c0;
        logic [7:0] body;
        logic [7:0] lpe0;
        logic [7:0] term;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{8'h00, 8'd0, 8'd0,   8'h0C, 8'h38, 8'h00},
        '{8'h10, 8'd2, 8'd3,   8'h0C, 8'h38, 8'h00},
        '{8'h30, 8'd4, 8'd1,   8'h04, 8'h39, 8'h01},
        '{8'h50, 8'd1, 8'd6,   8'h07, 8'h3B, 8'h00},
        '{8'h70, 8'd7, 8'd0,   8'h0B, 8'h38, 8'h01},
        '{8'h90, 8'd0, 8'd9,   8'h09, 8'h3B, 8'h00},
        '{8'hA0, 8'd3, 8'd255, 8'h0C, 8'h38, 8'h00},
        '{8'hF4, 8'd2, 8'd2,   8'h08, 8'h38, 8'h01}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start_i = 1'b0;
    logic [AW-1:0] start_addr_i = '0;
    logic [AW-1:0] fetch_addr_o;
    logic [7:0]    fetch_data_i;
    logic          op_valid_o;
    logic [1:0]    op_kind_o;
    logic          op_burst_o;
    logic [3:0]    chan_state_o;
    logic          fault_o;

    logic [7:0] mem [256];
    int nchk  = 0;
    int nfail = 0;

    always #4 clk = ~clk;

    assign fetch_data_i = mem[fetch_addr_o];

    lpseq_core #(.ADDR_W(AW)) uut (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start_i),
        .start_addr_i (start_addr_i),
        .fetch_addr_o (fetch_addr_o),
        .fetch_data_i (fetch_data_i),
        .op_valid_o   (op_valid_o),
        .op_kind_o    (op_kind_o),
        .op_burst_o   (op_burst_o),
        .chan_state_o (chan_state_o),
        .fault_o      (fault_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic put(input logic [7:0] a, input logic [7:0] d);
        mem[a] = d;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        start_i = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic load_nested(input vec_t v);
        logic [7:0] b;
        b = v.base;
        put(b + 8'd0,  8'hBC); put(b + 8'd1,  8'h01);
        put(b + 8'd2,  8'h11); put(b + 8'd3,  8'h22);
        put(b + 8'd4,  8'h33); put(b + 8'd5,  8'h44);
        put(b + 8'd6,  8'h22); put(b + 8'd7,  v.c1);
        put(b + 8'd8,  8'h20); put(b + 8'd9,  v.c0);
        put(b + 8'd10, v.body); put(b + 8'd11, 8'h18);
        put(b + 8'd12, v.lpe0); put(b + 8'd13, 8'd2);
        put(b + 8'd14, 8'h3C); put(b + 8'd15, 8'd6);
        put(b + 8'd16, v.term);
    endtask

    function automatic logic [1:0] exp_kind(input logic [7:0] op);
        if (op == 8'h0C) return 2'd3;
        if (op < 8'h08)  return 2'd1;
        return 2'd2;
    endfunction

    // Start a program and follow it until stopped, faulting or maxc cycles.
    task automatic run_prog(input logic [7:0] addr, input int maxc, input int inj,
                            input logic [1:0] ekind, input logic eburst,
                            output int nops, output int nbad, output logic [7:0] first,
                            output logic [3:0] last, output logic flt, output logic tmo);
        nops = 0; nbad = 0; last = 4'h1; flt = 1'b0; tmo = 1'b1; first = '0;
        start_addr_i = addr;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int c = 0; c < maxc; c++) begin
            if (c == 0) first = fetch_addr_o;
            if (op_valid_o) begin
                nops++;
                if (op_kind_o != ekind || op_burst_o != eburst) nbad++;
            end
            if (fault_o) begin flt = 1'b1; tmo = 1'b0; break; end
            if (chan_state_o == 4'h0) begin tmo = 1'b0; break; end
            last = chan_state_o;
            if (c == inj) begin
                start_i = 1'b1;
                start_addr_i = 8'h60;
            end else begin
                start_i = 1'b0;
            end
            @(negedge clk);
        end
        start_i = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        int nops, nbad;
        logic [7:0] first;
        logic [3:0] last;
        logic flt, tmo;

        for (int i = 0; i < 256; i++) mem[i] = 8'hFF;

        // R1: reset state
        @(negedge clk);
        chk(chan_state_o == 4'h0, "R1 state in reset", chan_state_o, 0);
        do_reset();
        chk(chan_state_o == 4'h0, "R1 state after reset", chan_state_o, 0);
        chk(fault_o == 1'b0, "R1 fault after reset", fault_o, 0);
        chk(op_valid_o == 1'b0, "R1 op after reset", op_valid_o, 0);
        repeat (4) @(negedge clk);
        chk(chan_state_o == 4'h0, "R2 stays stopped without start", chan_state_o, 0);

        // Nested-loop vectors: R2 R4 R5 R7 R8 R12
        for (int v = 0; v < NVEC; v++) begin
            load_nested(VECS[v]);
            run_prog(VECS[v].base, 20000, -1, exp_kind(VECS[v].body),
                     (VECS[v].body[1:0] == 2'b11), nops, nbad, first, last, flt, tmo);
            chk(first == VECS[v].base, "R2 R12 first fetch address", first, VECS[v].base);
            chk(!tmo && !flt, "R3 program ran to its end", {tmo, flt}, 0);
            chk(nops == (int'(VECS[v].c1) + 1) * (int'(VECS[v].c0) + 1),
                "R4 R5 command count", nops,
                (int'(VECS[v].c1) + 1) * (int'(VECS[v].c0) + 1));
            chk(nbad == 0, "R7 kind and burst tag", nbad, 0);
            chk(last == ((VECS[v].term == 8'h00) ? 4'h9 : 4'h8),
                "R8 exit state", last, (VECS[v].term == 8'h00) ? 9 : 8);
        end

        // R3: multi-byte instructions retire as no-operations
        put(8'h00, 8'h36); put(8'h01, 8'h08);
        put(8'h02, 8'h35); put(8'h03, 8'h10);
        put(8'h04, 8'h54); put(8'h05, 8'h34); put(8'h06, 8'h12);
        put(8'h07, 8'h12);
        put(8'h08, 8'h30); put(8'h09, 8'h00);
        put(8'h0A, 8'h0B);
        put(8'h0B, 8'h00);
        run_prog(8'h00, 200, -1, 2'd2, 1'b1, nops, nbad, first, last, flt, tmo);
        chk(nops == 1, "R3 one store after skipped ops", nops, 1);
        chk(nbad == 0, "R3 R7 store burst tag", nbad, 0);
        chk(!flt && !tmo && last == 4'h9, "R3 completes", last, 9);

        // R11: start while running is ignored
        load_nested(VECS[1]);
        put(8'h60, 8'h02);
        run_prog(VECS[1].base, 2000, 5, 2'd3, 1'b0, nops, nbad, first, last, flt, tmo);
        chk(nops == 12, "R11 count unchanged by start pulse", nops, 12);
        chk(!flt, "R11 no jump to restart address", flt, 0);

        // R6: forever loop keeps running
        put(8'h40, 8'h0C); put(8'h41, 8'h28); put(8'h42, 8'd1);
        run_prog(8'h40, 200, -1, 2'd3, 1'b0, nops, nbad, first, last, flt, tmo);
        chk(tmo && nops >= 20, "R6 forever loop repeats", nops, 20);
        chk(chan_state_o == 4'h1, "R6 still executing", chan_state_o, 1);
        do_reset();

        // R9: undefined opcode
        put(8'h60, 8'h0C); put(8'h61, 8'h02);
        run_prog(8'h60, 200, -1, 2'd3, 1'b0, nops, nbad, first, last, flt, tmo);
        chk(flt && nops == 1, "R9 fault after one command", nops, 1);
        repeat (5) @(negedge clk);
        chk(fault_o && chan_state_o == 4'hF, "R9 fault is sticky", chan_state_o, 15);
        chk(!op_valid_o, "R9 no command while faulting", op_valid_o, 0);
        do_reset();
        chk(!fault_o && chan_state_o == 4'h0, "R1 R9 reset clears fault", chan_state_o, 0);

        // R10: move with a bad selector
        put(8'h70, 8'hBC); put(8'h71, 8'h03);
        put(8'h72, 8'h00); put(8'h73, 8'h00); put(8'h74, 8'h00); put(8'h75, 8'h00);
        put(8'h76, 8'h00);
        run_prog(8'h70, 200, -1, 2'd3, 1'b0, nops, nbad, first, last, flt, tmo);
        chk(flt, "R10 bad selector faults", flt, 1);
        do_reset();
        put(8'h71, 8'h02);
        run_prog(8'h70, 200, -1, 2'd3, 1'b0, nops, nbad, first, last, flt, tmo);
        chk(!flt && last == 4'h9, "R10 selector 2 accepted", last, 9);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule